// File: doc/BRIEF.md
# Command Response Halfword Reader

This block sits behind the command line of an SD/MMC host. When a command is issued it is told which kind of response to expect. It then takes the response bytes as they come off an external deserialiser and keeps them in a small store. Software drains that store one 16-bit halfword per read strobe. Status flags report the end of the response, a response CRC mismatch and a response timeout, at the bit positions that the host status word decodes.

A short 48-bit response is kept whole: six bytes, read as three halfwords. Software rebuilds the 32-bit payload from the middle four bytes as `a<<24 | b<<8 | c>>8`. A long 136-bit response drops its leading header byte and keeps the remaining sixteen bytes as eight halfwords. Consecutive pairs of halfwords (high, then low) form four 32-bit words.

The CRC7 of a checked short response is computed inside the block, one byte per cycle. The serial CRC of the outgoing command is handled elsewhere.

Top module: `cmd_rsp_reader`

## Requirements
- R1: After reset `status_o` reads 0, `rd_data_o` reads 0 and the timeout limit holds 0xff.
- R2: `rsp_kind_i` is sampled together with `cmd_start_i`. The encodings are: 0 = no response, 1 = 48-bit with CRC check, 2 = 136-bit, 3 = 48-bit without CRC check.
- R3: A 48-bit response takes six bytes b0..b5 in arrival order. They are read as halfwords {b0,b1}, {b2,b3}, {b4,b5}, so `a<<24 | b<<8 | c>>8` equals {b1,b2,b3,b4}.
- R4: A 136-bit response takes seventeen bytes. The first is discarded and b1..b16 are read as eight halfwords {b1,b2} .. {b15,b16}. Halfwords 2w and 2w+1 form word w = {b(4w+1) .. b(4w+4)}.
- R5: `rd_data_o` shows the oldest unread complete halfword. A one-cycle `rd_en_i` pulse moves to the next halfword. When nothing is left, `rd_data_o` is 0 and a read does not move the pointer.
- R6: Status bit 13 (end of response) is set by the clock edge that accepts the final byte of the response.
- R7: For kind 1, the CRC7 (polynomial x^7+x^3+1, initial value 0, MSB first) of b0..b4 is compared with b5[7:1]. A mismatch sets status bit 5. Kinds 2 and 3 never set bit 5.
- R8: With timeout limit L, if no byte arrives after the command, status bits 1 and 13 are both set on the (L+1)th clock edge after the edge that accepted the command. A byte arriving earlier cancels the timeout.
- R9: The timeout limit is loaded from `tmo_val_i` when `tmo_we_i` is high.
- R10: `cmd_start_i` empties the store, rewinds the read pointer and clears all status bits before the new response is captured.
- R11: For kind 0, status bit 13 is set by the edge that accepts the command and no data is stored.
- R12: Bytes that arrive while no response is pending (idle, or after completion) change neither the store nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | A command has been issued; flush and arm capture |
| rsp_kind_i | input | 2 | Expected response kind, sampled with `cmd_start_i` |
| rsp_vld_i | input | 1 | `rsp_byte_i` carries a response byte this cycle |
| rsp_byte_i | input | 8 | Deserialised response byte, first byte first |
| tmo_we_i | input | 1 | Load the timeout limit |
| tmo_val_i | input | 8 | New timeout limit in clock cycles |
| rd_en_i | input | 1 | Pop the current halfword |
| rd_data_o | output | 16 | Current halfword, or 0 when none remains |
| status_o | output | 16 | Bit 13 end of response, bit 5 CRC error, bit 1 timeout |

## Verification
Every status bit is registered once: it is due on the edge that takes the final byte, on the edge that accepts a no-response command, or on the (L+1)th edge of waiting. `rd_data_o` is combinational from the store, so a popped halfword is replaced right after the edge that takes `rd_en_i`. The bench drives and samples on falling edges, so each check falls half a cycle after the edge that makes its result valid. The timeout window is probed on both sides of its boundary: one cycle early it must still read clear, and on the due cycle it must read set.

// File: rtl/cmd_rsp_pkg.sv
package cmd_rsp_pkg;

  typedef enum logic [1:0] {
    RSP_NONE      = 2'd0,
    RSP_SHORT_CRC = 2'd1,
    RSP_LONG      = 2'd2,
    RSP_SHORT     = 2'd3
  } rsp_kind_e;

  localparam int unsigned STAT_TMO_BIT = 1;
  localparam int unsigned STAT_CRC_BIT = 5;
  localparam int unsigned STAT_END_BIT = 13;
  localparam int unsigned SHORT_BYTES  = 6;

  // x^7 + x^3 + 1, MSB first
  function automatic logic [6:0] crc7_byte(input logic [6:0] crc, input logic [7:0] data);
    logic [6:0] c;
    logic       fb;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = data[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

endpackage

// File: rtl/cmd_rsp_crc7.sv
module cmd_rsp_crc7 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       upd_i,
  input  logic [7:0] byte_i,
  output logic [6:0] crc_o
);
  import cmd_rsp_pkg::*;

  logic [6:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (upd_i) crc_q <= crc7_byte(crc_q, byte_i);
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/cmd_rsp_seq.sv
module cmd_rsp_seq #(
  parameter int unsigned FIFO_HW = 8,
  parameter int unsigned TMO_W   = 8,
  parameter logic [TMO_W-1:0] TMO_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       kind_i,
  input  logic             byte_vld_i,
  input  logic [6:0]       crc_field_i,
  input  logic [6:0]       crc_i,
  input  logic             tmo_we_i,
  input  logic [TMO_W-1:0] tmo_val_i,
  output logic             wr_en_o,
  output logic             crc_upd_o,
  output logic             end_o,
  output logic             crc_err_o,
  output logic             tmo_o
);
  import cmd_rsp_pkg::*;

  localparam int unsigned LONG_BYTES = 2 * FIFO_HW + 1;
  localparam int unsigned CNT_W      = $clog2(LONG_BYTES + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_BYTES - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_BYTES - 1);

  rsp_kind_e        kind_q;
  logic             busy_q, got_q, end_q, crc_err_q, tmo_q;
  logic [CNT_W-1:0] cnt_q, last_idx;
  logic [TMO_W-1:0] tmo_cnt_q, tmo_lim_q;
  logic             take, is_last, crc_bad;

  assign last_idx = (kind_q == RSP_LONG) ? LONG_LAST : SHORT_LAST;
  assign take     = busy_q && byte_vld_i && !start_i;
  assign is_last  = (cnt_q == last_idx);
  assign crc_bad  = (kind_q == RSP_SHORT_CRC) && (crc_i != crc_field_i);

  // long responses drop their header byte
  assign wr_en_o   = take && !(kind_q == RSP_LONG && cnt_q == '0);
  assign crc_upd_o = take && (cnt_q < SHORT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tmo_lim_q <= TMO_RST;
    else if (tmo_we_i) tmo_lim_q <= tmo_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q    <= RSP_NONE;
      busy_q    <= 1'b0;
      got_q     <= 1'b0;
      cnt_q     <= '0;
      tmo_cnt_q <= '0;
      end_q     <= 1'b0;
      crc_err_q <= 1'b0;
      tmo_q     <= 1'b0;
    end else if (start_i) begin
      kind_q    <= rsp_kind_e'(kind_i);
      busy_q    <= (rsp_kind_e'(kind_i) != RSP_NONE);
      got_q     <= 1'b0;
      cnt_q     <= '0;
      tmo_cnt_q <= '0;
      end_q     <= (rsp_kind_e'(kind_i) == RSP_NONE);
      crc_err_q <= 1'b0;
      tmo_q     <= 1'b0;
    end else if (busy_q) begin
      if (byte_vld_i) begin
        got_q <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
        if (is_last) begin
          busy_q    <= 1'b0;
          end_q     <= 1'b1;
          crc_err_q <= crc_bad;
        end
      end else if (!got_q) begin
        if (tmo_cnt_q == tmo_lim_q) begin
          busy_q <= 1'b0;
          tmo_q  <= 1'b1;
          end_q  <= 1'b1;
        end else begin
          tmo_cnt_q <= tmo_cnt_q + 1'b1;
        end
      end
    end
  end

  assign end_o     = end_q;
  assign crc_err_o = crc_err_q;
  assign tmo_o     = tmo_q;

  // R8
  tmo_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q |-> end_q);
  // R7
  crc_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_q |-> (kind_q == RSP_SHORT_CRC));
  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> ($stable(end_q) && $stable(crc_err_q) && $stable(tmo_q)));
  // R8
  tmo_got_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_q) |-> !$past(got_q));

endmodule

// File: rtl/cmd_rsp_store.sv
module cmd_rsp_store #(
  parameter int unsigned FIFO_HW = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic        wr_en_i,
  input  logic [7:0]  wr_byte_i,
  input  logic        rd_en_i,
  output logic [15:0] rd_data_o
);
  localparam int unsigned FIFO_B = 2 * FIFO_HW;
  localparam int unsigned AW     = $clog2(FIFO_B);
  localparam int unsigned HAW    = $clog2(FIFO_HW);
  localparam int unsigned CW     = $clog2(FIFO_B + 1);
  localparam int unsigned PW     = $clog2(FIFO_HW + 1);

  logic [7:0]    mem_q [FIFO_B];
  logic [CW-1:0] wr_cnt_q;
  logic [PW-1:0] rd_ptr_q, valid_hw;
  logic [AW-1:0] hi_idx, lo_idx;
  logic          avail, do_wr;

  assign do_wr    = wr_en_i && (wr_cnt_q < CW'(FIFO_B));
  assign valid_hw = PW'(wr_cnt_q >> 1);
  assign avail    = (rd_ptr_q < valid_hw);
  assign hi_idx   = {rd_ptr_q[HAW-1:0], 1'b0};
  assign lo_idx   = {rd_ptr_q[HAW-1:0], 1'b1};
  assign rd_data_o = avail ? {mem_q[hi_idx], mem_q[lo_idx]} : 16'h0000;

  for (genvar g = 0; g < FIFO_B; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (!flush_i && do_wr && wr_cnt_q == CW'(g)) mem_q[g] <= wr_byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt_q <= '0;
      rd_ptr_q <= '0;
    end else if (flush_i) begin
      wr_cnt_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (do_wr)            wr_cnt_q <= wr_cnt_q + 1'b1;
      if (rd_en_i && avail) rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  // R10
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (wr_cnt_q == '0 && rd_ptr_q == '0));
  // R5
  pop_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !flush_i && avail) |=> (rd_ptr_q == $past(rd_ptr_q) + 1'b1));
  // R5
  over_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !avail) |=> $stable(rd_ptr_q));
  // R4
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_q <= CW'(FIFO_B));

endmodule

// File: rtl/cmd_rsp_reader.sv
module cmd_rsp_reader #(
  parameter int unsigned FIFO_HW = 8,
  parameter int unsigned TMO_W   = 8,
  parameter logic [TMO_W-1:0] TMO_RST = 8'hff
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_start_i,
  input  logic [1:0]       rsp_kind_i,
  input  logic             rsp_vld_i,
  input  logic [7:0]       rsp_byte_i,
  input  logic             tmo_we_i,
  input  logic [TMO_W-1:0] tmo_val_i,
  input  logic             rd_en_i,
  output logic [15:0]      rd_data_o,
  output logic [15:0]      status_o
);
  import cmd_rsp_pkg::*;

  logic       wr_en, crc_upd, end_f, crc_err_f, tmo_f;
  logic [6:0] crc;

  cmd_rsp_crc7 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cmd_start_i),
    .upd_i  (crc_upd),
    .byte_i (rsp_byte_i),
    .crc_o  (crc)
  );

  cmd_rsp_seq #(
    .FIFO_HW (FIFO_HW),
    .TMO_W   (TMO_W),
    .TMO_RST (TMO_RST)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (cmd_start_i),
    .kind_i      (rsp_kind_i),
    .byte_vld_i  (rsp_vld_i),
    .crc_field_i (rsp_byte_i[7:1]),
    .crc_i       (crc),
    .tmo_we_i    (tmo_we_i),
    .tmo_val_i   (tmo_val_i),
    .wr_en_o     (wr_en),
    .crc_upd_o   (crc_upd),
    .end_o       (end_f),
    .crc_err_o   (crc_err_f),
    .tmo_o       (tmo_f)
  );

  cmd_rsp_store #(
    .FIFO_HW (FIFO_HW)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (cmd_start_i),
    .wr_en_i   (wr_en),
    .wr_byte_i (rsp_byte_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o)
  );

  always_comb begin
    status_o               = '0;
    status_o[STAT_END_BIT] = end_f;
    status_o[STAT_CRC_BIT] = crc_err_f;
    status_o[STAT_TMO_BIT] = tmo_f;
  end

  // R11
  none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_i && rsp_kind_i == 2'd0) |=> (status_o[STAT_END_BIT] && rd_data_o == 16'h0000));
  // R10
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_i && rsp_kind_i != 2'd0) |=> (status_o == 16'h0000 && rd_data_o == 16'h0000));

endmodule

// File: tb/tb_cmd_rsp_reader.sv
module tb_cmd_rsp_reader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [1:0]  kind = 2'd0;
  logic        rsp_vld = 1'b0;
  logic [7:0]  rsp_byte = 8'h00;
  logic        tmo_we = 1'b0;
  logic [7:0]  tmo_val = 8'h00;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data, status;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cmd_rsp_reader dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_start_i (cmd_start),
    .rsp_kind_i  (kind),
    .rsp_vld_i   (rsp_vld),
    .rsp_byte_i  (rsp_byte),
    .tmo_we_i    (tmo_we),
    .tmo_val_i   (tmo_val),
    .rd_en_i     (rd_en),
    .rd_data_o   (rd_data),
    .status_o    (status)
  );

  // vector: kind[15:14], corrupt[13], seed[7:0]; expected status alongside
  localparam logic [15:0] VEC [6] = '{16'h4011, 16'h602a, 16'he033, 16'h8040, 16'hc005, 16'h80c3};
  localparam logic [15:0] VEXP[6] = '{16'h2000, 16'h2020, 16'h2000, 16'h2000, 16'h2000, 16'h2000};

  function automatic logic [6:0] ref_crc7(input logic [7:0] b [17]);
    logic [6:0] r = '0;
    for (int k = 0; k < 5; k++)
      for (int j = 7; j >= 0; j--) begin
        logic top;
        top = r[6] ^ b[k][j];
        r = {r[5:0], 1'b0} ^ (top ? 7'b0001001 : 7'b0);
      end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_cmd(input logic [1:0] k);
    cmd_start = 1'b1; kind = k;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    rsp_vld = 1'b1; rsp_byte = b;
    @(negedge clk);
    rsp_vld = 1'b0;
  endtask

  task automatic pop_check(input string req, input logic [15:0] exp);
    check(req, {16'h0, rd_data}, {16'h0, exp});
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  b [17];
    logic [15:0] hw [8];
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", {16'h0, status}, 32'h0);
    check("R1 rd_data", {16'h0, rd_data}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after release", {16'h0, status}, 32'h0);

    // table walk: R2 R3 R4 R6 R7
    for (int v = 0; v < 6; v++) begin
      logic [1:0] k;
      int nb, nh;
      k  = VEC[v][15:14];
      nb = (k == 2'd2) ? 17 : 6;
      nh = (k == 2'd2) ? 8 : 3;
      for (int i = 0; i < 17; i++) b[i] = 8'(VEC[v][7:0] * (i + 1) + i * 29);
      if (k != 2'd2) begin
        b[5] = {ref_crc7(b), 1'b1};
        if (VEC[v][13]) b[5] = b[5] ^ 8'h02;
      end
      start_cmd(k);
      for (int i = 0; i < nb; i++) send(b[i]);
      check("R6 R7 status", {16'h0, status}, {16'h0, VEXP[v]});
      for (int h = 0; h < nh; h++) begin
        hw[h] = rd_data;
        if (k == 2'd2) pop_check("R4 halfword", {b[2*h+1], b[2*h+2]});
        else           pop_check("R3 halfword", {b[2*h], b[2*h+1]});
      end
      if (k == 2'd2) begin
        for (int w = 0; w < 4; w++)
          check("R4 word", {hw[2*w], hw[2*w+1]}, {b[4*w+1], b[4*w+2], b[4*w+3], b[4*w+4]});
      end else begin
        check("R3 payload", ({16'h0, hw[0]} << 24) | ({16'h0, hw[1]} << 8) | ({16'h0, hw[2]} >> 8),
              {b[1], b[2], b[3], b[4]});
      end
      pop_check("R5 past end", 16'h0000);
      check("R5 still zero", {16'h0, rd_data}, 32'h0);
    end

    // R11 no response
    start_cmd(2'd0);
    check("R11 end flag", {16'h0, status}, 32'h2000);
    check("R11 no data", {16'h0, rd_data}, 32'h0);
    send(8'haa);
    check("R12 idle byte ignored status", {16'h0, status}, 32'h2000);
    check("R12 idle byte ignored data", {16'h0, rd_data}, 32'h0);

    // R12 extra byte after completion
    start_cmd(2'd3);
    for (int i = 0; i < 6; i++) send(8'h10 + 8'(i));
    send(8'hee);
    send(8'hff);
    check("R12 status kept", {16'h0, status}, 32'h2000);
    pop_check("R12 hw0", 16'h1011);
    pop_check("R12 hw1", 16'h1213);
    pop_check("R12 hw2", 16'h1415);
    check("R12 nothing extra", {16'h0, rd_data}, 32'h0);

    // R10 flush mid-read
    start_cmd(2'd3);
    for (int i = 0; i < 6; i++) send(8'h20 + 8'(i));
    pop_check("R10 pre-flush hw0", 16'h2021);
    start_cmd(2'd1);
    check("R10 status cleared", {16'h0, status}, 32'h0);
    check("R10 store empty", {16'h0, rd_data}, 32'h0);

    // R8 R9 timeout with limit 4
    tmo_we = 1'b1; tmo_val = 8'd4;
    @(negedge clk);
    tmo_we = 1'b0;
    start_cmd(2'd1);
    repeat (4) @(negedge clk);
    check("R8 not yet timed out", {16'h0, status}, 32'h0);
    @(negedge clk);
    check("R8 timeout flags", {16'h0, status}, 32'h2002);

    // R8 byte cancels timeout
    start_cmd(2'd3);
    repeat (2) @(negedge clk);
    send(8'h31);
    repeat (10) @(negedge clk);
    check("R8 no timeout after byte", {16'h0, status}, 32'h0);
    for (int i = 1; i < 6; i++) send(8'h31 + 8'(i));
    check("R8 completes normally", {16'h0, status}, 32'h2000);

    // R1 R9 default limit 0xff after a fresh reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    start_cmd(2'd2);
    repeat (255) @(negedge clk);
    check("R1 R9 default limit early", {16'h0, status}, 32'h0);
    @(negedge clk);
    check("R1 R9 default limit due", {16'h0, status}, 32'h2002);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule